// File: doc/BRIEF.md
# DMA Interrupt Status and Summary Register

This block collects the event flags of an Ethernet-style DMA engine's transmit and receive paths. Each event arrives as a one-cycle pulse and is held as a sticky status bit until software clears it by writing 1 to it. A separate enable register masks each event and forms two sticky summary bits. The normal summary gathers the routine completion events. The abnormal summary gathers the error and stall events. A single interrupt line is raised from the summaries, each gated by an enable bit of its own.

The status word also carries the current state codes of the transmit and receive DMA state machines. These are read-only and never feed an interrupt. Software reads and writes both words over a simple register bus with a registered read path.

Top module: `dma_irq_status`

## Requirements
- R1: Each implemented event bit of the status word (positions 0 to 10, 13 and 14) sets on a pulse at the same position of `ev_pulse`. It stays set until a status write carries 1 in that position. A write carrying 0 there leaves it unchanged.
- R2: When an event pulse and a clearing write hit the same bit in the same cycle, the bit is set after that edge.
- R3: The early-receive bit (14) clears when a receive-complete pulse (position 6) arrives, and also when both pulses arrive in the same cycle.
- R4: The normal summary (status bit 16) sets when any of event bits 0, 2, 6 or 14 is set while its enable bit (same position in the enable word) is 1.
- R5: The abnormal summary (status bit 15) sets when any of event bits 1, 3, 4, 5, 7, 8, 9, 10 or 13 is set while its enable bit is 1.
- R6: An event whose enable bit is 0 sets neither summary.
- R7: The summaries are sticky and are cleared only by writing 1 to bit 16 or bit 15. The clear takes effect when no enabled source of that summary remains set after the same write. Otherwise the summary sets again at once.
- R8: `irq` is 1 one cycle after the normal summary is set with enable bit 16 set, or after the abnormal summary is set with enable bit 15 set. It is 0 one cycle after neither holds.
- R9: Status bits 22:20 read the transmit state code and bits 19:17 read the receive state code, all eight codes passed through unchanged. Writes do not alter them, and they never affect the summaries or `irq`.
- R10: The status word is at address 0 and the enable word at address 1. After reset both read zero and `irq` is 0.
- R11: Reserved positions (11, 12 and 31:23 of status; 11, 12 and 31:17 of enable) read zero, and writes to them are ignored. Other addresses read zero.
- R12: `rdata` shows the word selected by `addr` one clock edge after `addr` is presented. It keeps its previous value until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Registered read data |
| ev_pulse | input | 15 | Event pulses, bit n sets status bit n |
| tx_state | input | 3 | Transmit DMA state code |
| rx_state | input | 3 | Receive DMA state code |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions take for granted that all inputs are synchronous to `clk` and that reset is held for at least one edge before the first access. They assume nothing about pulse width or about how often pulses occur. The stimulus changes every input only on the falling edge and keeps each event pulse to one cycle. It performs at most one bus write per cycle. The state-code inputs are held at zero while the event vectors run, so each expected status word can be written out in full.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int DATA_W = 32;
  localparam int EVT_W  = 15;
  localparam int ST_W   = 3;

  // implemented event positions and the two summary groups
  localparam logic [EVT_W-1:0] EVT_IMPL = 15'h67FF;
  localparam logic [EVT_W-1:0] NORM_GRP = 15'h4045;
  localparam logic [EVT_W-1:0] ABN_GRP  = 15'h27BA;

  localparam int BIT_RX_DONE  = 6;
  localparam int BIT_RX_EARLY = 14;
  localparam int BIT_ABN_SUM  = 15;
  localparam int BIT_NORM_SUM = 16;
  localparam int RX_ST_LSB    = 17;
  localparam int TX_ST_LSB    = 20;

  typedef struct packed {
    logic norm;
    logic abn;
  } summary_t;
endpackage

// File: rtl/irq_event_bank.sv
module irq_event_bank
  import dma_irq_pkg::*;
#(
  parameter int               W         = EVT_W,
  parameter logic [W-1:0]     IMPL      = EVT_IMPL,
  parameter int               EARLY_BIT = BIT_RX_EARLY,
  parameter int               DONE_BIT  = BIT_RX_DONE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev_pulse,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] ev_q,
  output logic [W-1:0] ev_next
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == EARLY_BIT) begin : g_early
      // the completion event retires the early flag, even on a coincident set
      assign ev_next[i] = IMPL[i] & (ev_pulse[i] | (ev_q[i] & ~clr_mask[i]))
                          & ~ev_pulse[DONE_BIT];

      AST_EARLY_AUTOCLR: assert property (@(posedge clk) disable iff (rst)
        ev_pulse[DONE_BIT] |=> !ev_q[i]); // R3
    end else begin : g_plain
      // a set pulse outranks a clearing write
      assign ev_next[i] = IMPL[i] & (ev_pulse[i] | (ev_q[i] & ~clr_mask[i]));

      if (IMPL[i]) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
          ev_pulse[i] |=> ev_q[i]); // R2
        AST_HOLD_UNTIL_CLR: assert property (@(posedge clk) disable iff (rst)
          (ev_q[i] && !clr_mask[i]) |=> ev_q[i]); // R1
        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
          (!ev_q[i] && !ev_pulse[i]) |=> !ev_q[i]); // R1
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ev_q <= '0;
    else     ev_q <= ev_next;
  end

endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import dma_irq_pkg::*;
#(
  parameter int           W    = EVT_W,
  parameter logic [W-1:0] NORM = NORM_GRP,
  parameter logic [W-1:0] ABN  = ABN_GRP
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev_next,
  input  logic [W-1:0] en_evt,
  input  logic         en_norm,
  input  logic         en_abn,
  input  logic         clr_norm,
  input  logic         clr_abn,
  output summary_t     sum,
  output logic         irq
);

  logic src_norm, src_abn;
  summary_t sum_d;

  // sources use the post-write event image so one write can clear both levels
  assign src_norm = |(ev_next & en_evt & NORM);
  assign src_abn  = |(ev_next & en_evt & ABN);

  always_comb begin
    sum_d.norm = src_norm | (sum.norm & ~clr_norm);
    sum_d.abn  = src_abn  | (sum.abn  & ~clr_abn);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum <= '0;
      irq <= 1'b0;
    end else begin
      sum <= sum_d;
      irq <= (sum.norm & en_norm) | (sum.abn & en_abn);
    end
  end

  AST_NORM_SET: assert property (@(posedge clk) disable iff (rst)
    (|(ev_next & en_evt & NORM)) |=> sum.norm); // R4
  AST_ABN_SET: assert property (@(posedge clk) disable iff (rst)
    (|(ev_next & en_evt & ABN)) |=> sum.abn); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!sum.norm && !sum.abn && !(|(ev_next & en_evt))) |=> (!sum.norm && !sum.abn)); // R6
  AST_SUM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sum.norm && !clr_norm) |=> sum.norm); // R7
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    ((sum.norm && en_norm) || (sum.abn && en_abn)) |=> irq); // R8
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    !((sum.norm && en_norm) || (sum.abn && en_abn)) |=> !irq); // R8

endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import dma_irq_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic [EVT_W-1:0]  ev_q,
  input  summary_t          sum,
  input  logic [ST_W-1:0]   tx_state,
  input  logic [ST_W-1:0]   rx_state,
  output logic [EVT_W-1:0]  clr_evt,
  output logic              clr_norm,
  output logic              clr_abn,
  output logic [EVT_W-1:0]  en_evt,
  output logic              en_norm,
  output logic              en_abn,
  output logic [DATA_W-1:0] rdata
);

  localparam int TOP_USED = TX_ST_LSB + ST_W;

  logic wr_status, wr_enable;
  logic [DATA_W-1:0] status_img, enable_img;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:BIT_NORM_SUM+1];

  assign wr_status = wr_en && (addr == STATUS_ADDR);
  assign wr_enable = wr_en && (addr == ENABLE_ADDR);

  assign clr_evt  = wr_status ? (wdata[EVT_W-1:0] & EVT_IMPL) : '0;
  assign clr_abn  = wr_status & wdata[BIT_ABN_SUM];
  assign clr_norm = wr_status & wdata[BIT_NORM_SUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_evt  <= '0;
      en_norm <= 1'b0;
      en_abn  <= 1'b0;
    end else if (wr_enable) begin
      en_evt  <= wdata[EVT_W-1:0] & EVT_IMPL;
      en_abn  <= wdata[BIT_ABN_SUM];
      en_norm <= wdata[BIT_NORM_SUM];
    end
  end

  always_comb begin
    status_img = '0;
    status_img[EVT_W-1:0] = ev_q;
    status_img[BIT_ABN_SUM] = sum.abn;
    status_img[BIT_NORM_SUM] = sum.norm;
    status_img[RX_ST_LSB +: ST_W] = rx_state;
    status_img[TX_ST_LSB +: ST_W] = tx_state;

    enable_img = '0;
    enable_img[EVT_W-1:0] = en_evt;
    enable_img[BIT_ABN_SUM] = en_abn;
    enable_img[BIT_NORM_SUM] = en_norm;
  end

  always_ff @(posedge clk) begin
    if (rst)                       rdata <= '0;
    else if (addr == STATUS_ADDR)  rdata <= status_img;
    else if (addr == ENABLE_ADDR)  rdata <= enable_img;
    else                           rdata <= '0;
  end

  AST_RSVD_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:TOP_USED] == '0); // R11
  AST_RSVD_GAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdata[12:11] == 2'b00)); // R11
  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_enable |=> ($stable(en_evt) && $stable(en_norm) && $stable(en_abn))); // R10

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rdata,
  input  logic [EVT_W-1:0]  ev_pulse,
  input  logic [ST_W-1:0]   tx_state,
  input  logic [ST_W-1:0]   rx_state,
  output logic              irq
);

  logic [EVT_W-1:0] ev_q, ev_next, clr_evt, en_evt;
  logic             clr_norm, clr_abn, en_norm, en_abn;
  summary_t         sum;

  irq_event_bank #(
    .W(EVT_W), .IMPL(EVT_IMPL), .EARLY_BIT(BIT_RX_EARLY), .DONE_BIT(BIT_RX_DONE)
  ) u_bank (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .clr_mask(clr_evt),
    .ev_q(ev_q), .ev_next(ev_next)
  );

  irq_summary #(
    .W(EVT_W), .NORM(NORM_GRP), .ABN(ABN_GRP)
  ) u_sum (
    .clk(clk), .rst(rst), .ev_next(ev_next), .en_evt(en_evt),
    .en_norm(en_norm), .en_abn(en_abn), .clr_norm(clr_norm), .clr_abn(clr_abn),
    .sum(sum), .irq(irq)
  );

  irq_regif #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .ENABLE_ADDR(ENABLE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .ev_q(ev_q), .sum(sum), .tx_state(tx_state), .rx_state(rx_state),
    .clr_evt(clr_evt), .clr_norm(clr_norm), .clr_abn(clr_abn),
    .en_evt(en_evt), .en_norm(en_norm), .en_abn(en_abn), .rdata(rdata)
  );

endmodule

// File: tb/tb_dma_irq_status.sv
`timescale 1ns/1ps
module tb_dma_irq_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rdata;
  logic [14:0] ev_pulse = '0;
  logic [2:0]  tx_state = '0;
  logic [2:0]  rx_state = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  dma_irq_status dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .ev_pulse(ev_pulse), .tx_state(tx_state),
    .rx_state(rx_state), .irq(irq)
  );

  typedef struct packed {
    logic [14:0] pulse;
    logic [31:0] en;
    logic [31:0] st;
    logic        irq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{15'h0001, 32'h0001_0001, 32'h0001_0001, 1'b1},  // R4 normal, enabled
    '{15'h0001, 32'h0000_0001, 32'h0001_0001, 1'b0},  // R8 summary without its enable
    '{15'h0002, 32'h0000_8002, 32'h0000_8002, 1'b1},  // R5 abnormal, enabled
    '{15'h0002, 32'h0001_0002, 32'h0000_8002, 1'b0},  // R8 wrong summary enable
    '{15'h2000, 32'h0000_0000, 32'h0000_2000, 1'b0},  // R6 masked
    '{15'h4040, 32'h0001_4040, 32'h0001_0040, 1'b1},  // R3 coincident early + done
    '{15'h4000, 32'h0001_4000, 32'h0001_4000, 1'b1},  // R4 early alone
    '{15'h0800, 32'h0001_FFFF, 32'h0000_0000, 1'b0},  // R11 reserved pulse
    '{15'h67FF, 32'h0001_E7FF, 32'h0001_A7FF, 1'b1},  // R4 R5 all events
    '{15'h0400, 32'h0000_0004, 32'h0000_0400, 1'b0}   // R6 masked abnormal
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic fire(input logic [14:0] p);
    @(negedge clk); ev_pulse = p;
    @(negedge clk); ev_pulse = '0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    bus_read(4'd0, v); chk("R10 status after reset", v, 32'h0);
    bus_read(4'd1, v); chk("R10 enable after reset", v, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      bus_write(4'd0, 32'h0001_FFFF);
      bus_write(4'd1, VECS[i].en);
      fire(VECS[i].pulse);
      repeat (2) @(negedge clk);
      chk($sformatf("R8 vector %0d irq", i), {31'b0, irq}, {31'b0, VECS[i].irq});
      bus_read(4'd0, v);
      chk($sformatf("R1 R4 R5 vector %0d status", i), v, VECS[i].st);
    end

    // R11 enable readback masks reserved bits
    bus_write(4'd1, 32'hFFFF_FFFF);
    bus_read(4'd1, v); chk("R11 enable reserved bits", v, 32'h0001_E7FF);
    bus_read(4'd7, v); chk("R11 unmapped address", v, 32'h0);

    // R1 hold through unrelated writes
    bus_write(4'd1, 32'h0);
    bus_write(4'd0, 32'h0001_FFFF);
    fire(15'h0008);
    bus_write(4'd0, 32'h0);
    bus_write(4'd0, 32'h0000_0010);
    bus_read(4'd0, v); chk("R1 bit holds", v, 32'h0000_0008);
    bus_write(4'd0, 32'h0000_0008);
    bus_read(4'd0, v); chk("R1 bit cleared", v, 32'h0);

    // R2 set and clear in the same cycle
    @(negedge clk); addr = 4'd0; wdata = 32'h0000_0020; wr_en = 1'b1; ev_pulse = 15'h0020;
    @(negedge clk); wr_en = 1'b0; ev_pulse = '0;
    bus_read(4'd0, v); chk("R2 set wins", v, 32'h0000_0020);
    bus_write(4'd0, 32'h0000_0020);

    // R3 separate cycles
    fire(15'h4000);
    bus_read(4'd0, v); chk("R3 early set", v, 32'h0000_4000);
    fire(15'h0040);
    bus_read(4'd0, v); chk("R3 early retired", v, 32'h0000_0040);
    bus_write(4'd0, 32'h0000_0040);

    // R7 sticky summary and R8 timing
    bus_write(4'd1, 32'h0001_0001);
    @(negedge clk); ev_pulse = 15'h0001;
    @(negedge clk); ev_pulse = '0;
    chk("R8 irq one cycle after summary", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    bus_write(4'd0, 32'h0001_0000);
    bus_read(4'd0, v); chk("R7 summary re-sets while source live", v, 32'h0001_0001);
    bus_write(4'd0, 32'h0000_0001);
    bus_read(4'd0, v); chk("R7 summary survives event clear", v, 32'h0001_0000);
    chk("R7 irq still high", {31'b0, irq}, 32'h1);
    bus_write(4'd0, 32'h0001_0000);
    @(negedge clk);
    bus_read(4'd0, v); chk("R7 summary cleared", v, 32'h0);
    chk("R8 irq dropped", {31'b0, irq}, 32'h0);

    // R9 state fields
    bus_write(4'd1, 32'h0001_E7FF);
    @(negedge clk); tx_state = 3'b110; rx_state = 3'b111;
    bus_write(4'd0, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    bus_read(4'd0, v); chk("R9 state fields", v, 32'h006E_0000);
    chk("R9 no interrupt from states", {31'b0, irq}, 32'h0);
    @(negedge clk); tx_state = 3'b101; rx_state = 3'b010;
    bus_read(4'd0, v); chk("R9 reserved codes pass", v, 32'h0054_0000);
    @(negedge clk); tx_state = '0; rx_state = '0;

    // R12 read latency
    bus_write(4'd1, 32'h0000_0005);
    bus_read(4'd1, v); chk("R12 enable after one edge", v, 32'h0000_0005);
    @(negedge clk); addr = 4'd0;
    chk("R12 old data before edge", rdata, 32'h0000_0005);
    @(negedge clk);
    chk("R12 new data after edge", rdata, 32'h0);

    finish_run();
  end
endmodule